// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block sequences the operating modes of a CAN protocol controller. It turns the halt, freeze-enable, debug and disable control bits into an orderly entry to a frozen configuration mode or to a clock-gated low-power mode. Neither entry is allowed to cut a frame or an internal buffer transfer in half. While frozen it stops the bit-time prescaler, isolates the controller from the bus and opens the error counters to writes. On leaving either mode it holds the controller off the bus until the line has shown enough consecutive recessive bits to be known idle.

The protocol engine supplies its current bus state, a busy flag for internal activity (arbitration, matching, buffer moves), a strobe for each sampled bus bit, and the position of the current bit within intermission. The outputs go straight to the prescaler, the Rx/Tx pads, the error-counter write path and the submodule clock gates. The acknowledge and not-ready flags are the status the register file shows to software. After reset the block starts in bus resynchronisation.

Top module: `can_mode_seq`

## Requirements
- R1: A freeze request exists only when `frz_en_i` is 1, at least one of `halt_i` or `debug_i` is 1, and `mdis_i` is 0. With an idle bus (`bus_state_i` = 0) and `busy_i` = 0, `frz_ack_o` rises on the third clock edge after the request appears.
- R2: Freeze entry first waits for a safe bus state: 0 (idle), 2 (intermission), 3 (error passive) or 4 (bus off). Codes 1 and 5 to 7 are frame traffic and keep it waiting. It then waits for `busy_i` = 0. `frz_ack_o` rises on the edge after the one where `busy_i` is seen low.
- R3: While frozen, `presc_en_o` = 0, `rx_ignore_o` = 1 and `tx_rec_o` = 1.
- R4: `ecr_we_o` is 1 only while frozen, and 0 in run, wait, disabled and resync states.
- R5: While frozen, `frz_ack_o` and `not_rdy_o` are both 1.
- R6: Freeze ends on the edge after the request is lost, whether by clearing `frz_en_i` or by clearing both `halt_i` and `debug_i`. `frz_ack_o` then drops and `not_rdy_o` stays 1.
- R7: In resynchronisation, each `bit_tick_i` with `rx_bit_i` = 1 (recessive) counts one bit, and a tick with `rx_bit_i` = 0 resets the count to zero. `not_rdy_o` drops on the edge that takes the eleventh consecutive recessive bit.
- R8: If `mdis_i` is 1 while frozen, the next edge drives all `clk_en_o` bits to 0, sets `lpm_ack_o` and clears `frz_ack_o`.
- R9: Disable entry during operation waits for bus state 0 or 4. It may instead proceed on a recessive tick at intermission (state 2) with `intm_pos_i` = 2, the third bit. A dominant third bit keeps it waiting. It then waits for `busy_i` = 0, after which `lpm_ack_o` rises on the next edge.
- R10: On the edge after `mdis_i` is seen low in disabled mode, `lpm_ack_o` clears and all `clk_en_o` bits return to 1. `not_rdy_o` stays 1 until resynchronisation completes.
- R11: A request that changes while an entry wait is pending is only re-evaluated once the wait resolves. A freeze request dropped during the bus-state wait still ends in a one-cycle frozen state.
- R12: After reset, `not_rdy_o` = 1, `frz_ack_o` = 0, `lpm_ack_o` = 0, `presc_en_o` = 1, `ecr_we_o` = 0 and all `clk_en_o` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Software halt bit |
| frz_en_i | input | 1 | Freeze enable bit |
| debug_i | input | 1 | Chip debug mode active |
| mdis_i | input | 1 | Module disable request |
| bus_state_i | input | 3 | Protocol state: 0 idle, 1 frame, 2 intermission, 3 error passive, 4 bus off |
| busy_i | input | 1 | Internal activity (arbitration, matching, buffer moves) in progress |
| bit_tick_i | input | 1 | One-cycle strobe per sampled bus bit |
| rx_bit_i | input | 1 | Sampled bus bit, 1 = recessive |
| intm_pos_i | input | 2 | Bit index inside intermission, 0-based |
| frz_ack_o | output | 1 | Freeze acknowledge |
| not_rdy_o | output | 1 | Controller not on the bus |
| lpm_ack_o | output | 1 | Low-power acknowledge |
| presc_en_o | output | 1 | Bit-time prescaler run enable |
| rx_ignore_o | output | 1 | Ignore Rx input |
| tx_rec_o | output | 1 | Force Tx recessive |
| ecr_we_o | output | 1 | Error counter write enable |
| clk_en_o | output | 2 | Submodule clock gate enables |

## Verification
The hardest case to reach is disable entry on the third intermission bit, because it depends on the bit position and the sampled level at the same strobe. The bench parks the engine in intermission with a pending disable. It then steps through bit positions 0 and 1, gives a dominant third bit, and finally a recessive third bit, checking that only the last one releases the wait. It also reaches the deferred-request case by dropping a freeze request while the bus-state wait is blocked, then freeing the bus and catching the single frozen cycle.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int BUS_W = 3;

  localparam logic [BUS_W-1:0] BUS_IDLE     = 3'd0;
  localparam logic [BUS_W-1:0] BUS_FRAME    = 3'd1;
  localparam logic [BUS_W-1:0] BUS_INTM     = 3'd2;
  localparam logic [BUS_W-1:0] BUS_ERR_PASV = 3'd3;
  localparam logic [BUS_W-1:0] BUS_OFF      = 3'd4;

  typedef enum logic [2:0] {
    M_RUN,
    M_FRZ_WAIT_ST,
    M_FRZ_WAIT_ACT,
    M_FROZEN,
    M_DIS_WAIT_ST,
    M_DIS_WAIT_ACT,
    M_DISABLED,
    M_RESYNC
  } mode_e;

  function automatic logic frz_safe_state(input logic [BUS_W-1:0] s);
    return (s == BUS_IDLE) || (s == BUS_INTM) || (s == BUS_ERR_PASV) || (s == BUS_OFF);
  endfunction

  function automatic logic dis_safe_state(input logic [BUS_W-1:0] s);
    return (s == BUS_IDLE) || (s == BUS_OFF);
  endfunction
endpackage

// File: rtl/can_mode_req.sv
module can_mode_req (
  input  logic halt_i,
  input  logic frz_en_i,
  input  logic debug_i,
  input  logic mdis_i,
  output logic frz_req_o,
  output logic dis_req_o
);
  assign frz_req_o = frz_en_i & (halt_i | debug_i) & ~mdis_i;
  assign dis_req_o = mdis_i;
endmodule

// File: rtl/can_mode_resync.sv
module can_mode_resync #(
  parameter int RESYNC_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic rx_bit_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(RESYNC_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RESYNC_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= rx_bit_i ? cnt_q + 1'b1 : '0;
  end

  assign done_o = ~clr_i & tick_i & rx_bit_i & (cnt_q == LAST);
endmodule

// File: rtl/can_mode_out.sv
module can_mode_out
  import can_mode_pkg::*;
#(
  parameter int NUM_CLK_GATES = 2
) (
  input  mode_e                    mode_i,
  output logic                     frz_ack_o,
  output logic                     not_rdy_o,
  output logic                     lpm_ack_o,
  output logic                     presc_en_o,
  output logic                     rx_ignore_o,
  output logic                     tx_rec_o,
  output logic                     ecr_we_o,
  output logic [NUM_CLK_GATES-1:0] clk_en_o
);
  logic frozen, disabled;

  assign frozen      = (mode_i == M_FROZEN);
  assign disabled    = (mode_i == M_DISABLED);
  assign frz_ack_o   = frozen;
  assign lpm_ack_o   = disabled;
  assign not_rdy_o   = frozen | disabled | (mode_i == M_RESYNC);
  assign presc_en_o  = ~(frozen | disabled);
  assign rx_ignore_o = frozen | disabled;
  assign tx_rec_o    = frozen | disabled;
  assign ecr_we_o    = frozen;

  for (genvar g = 0; g < NUM_CLK_GATES; g++) begin : g_gate
    assign clk_en_o[g] = ~disabled;
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RESYNC_BITS    = 11,
  parameter int INTM_POS_W     = 2,
  parameter int INTM_CHECK_POS = 2,
  parameter int NUM_CLK_GATES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     halt_i,
  input  logic                     frz_en_i,
  input  logic                     debug_i,
  input  logic                     mdis_i,
  input  logic [BUS_W-1:0]         bus_state_i,
  input  logic                     busy_i,
  input  logic                     bit_tick_i,
  input  logic                     rx_bit_i,
  input  logic [INTM_POS_W-1:0]    intm_pos_i,
  output logic                     frz_ack_o,
  output logic                     not_rdy_o,
  output logic                     lpm_ack_o,
  output logic                     presc_en_o,
  output logic                     rx_ignore_o,
  output logic                     tx_rec_o,
  output logic                     ecr_we_o,
  output logic [NUM_CLK_GATES-1:0] clk_en_o
);
  localparam logic [INTM_POS_W-1:0] CHECK_POS = INTM_POS_W'(INTM_CHECK_POS);

  mode_e mode_q, mode_d;
  logic  frz_req, dis_req, resync_done, intm_ok;

  can_mode_req u_req (
    .halt_i   (halt_i),
    .frz_en_i (frz_en_i),
    .debug_i  (debug_i),
    .mdis_i   (mdis_i),
    .frz_req_o(frz_req),
    .dis_req_o(dis_req)
  );

  can_mode_resync #(.RESYNC_BITS(RESYNC_BITS)) u_resync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_q != M_RESYNC),
    .tick_i  (bit_tick_i),
    .rx_bit_i(rx_bit_i),
    .done_o  (resync_done)
  );

  // third intermission bit sampled recessive
  assign intm_ok = (bus_state_i == BUS_INTM) & bit_tick_i & rx_bit_i &
                   (intm_pos_i == CHECK_POS);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_RUN: begin
        if (dis_req)      mode_d = M_DIS_WAIT_ST;
        else if (frz_req) mode_d = M_FRZ_WAIT_ST;
      end
      M_FRZ_WAIT_ST:  if (frz_safe_state(bus_state_i)) mode_d = M_FRZ_WAIT_ACT;
      M_FRZ_WAIT_ACT: if (!busy_i) mode_d = M_FROZEN;
      M_FROZEN: begin
        if (dis_req)       mode_d = M_DISABLED;
        else if (!frz_req) mode_d = M_RESYNC;
      end
      M_DIS_WAIT_ST:
        if (dis_safe_state(bus_state_i) || intm_ok) mode_d = M_DIS_WAIT_ACT;
      M_DIS_WAIT_ACT: if (!busy_i) mode_d = M_DISABLED;
      M_DISABLED:     if (!dis_req) mode_d = M_RESYNC;
      M_RESYNC: begin
        if (dis_req)          mode_d = M_DIS_WAIT_ACT;
        else if (frz_req)     mode_d = M_FRZ_WAIT_ACT;
        else if (resync_done) mode_d = M_RUN;
      end
      default: mode_d = M_RESYNC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= M_RESYNC;
    else         mode_q <= mode_d;
  end

  can_mode_out #(.NUM_CLK_GATES(NUM_CLK_GATES)) u_out (
    .mode_i     (mode_q),
    .frz_ack_o  (frz_ack_o),
    .not_rdy_o  (not_rdy_o),
    .lpm_ack_o  (lpm_ack_o),
    .presc_en_o (presc_en_o),
    .rx_ignore_o(rx_ignore_o),
    .tx_rec_o   (tx_rec_o),
    .ecr_we_o   (ecr_we_o),
    .clk_en_o   (clk_en_o)
  );
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
  parameter int NUM_CLK_GATES = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     mdis_i,
  input logic                     busy_i,
  input logic                     bit_tick_i,
  input logic                     rx_bit_i,
  input logic                     frz_ack_o,
  input logic                     not_rdy_o,
  input logic                     lpm_ack_o,
  input logic                     presc_en_o,
  input logic                     rx_ignore_o,
  input logic                     tx_rec_o,
  input logic                     ecr_we_o,
  input logic [NUM_CLK_GATES-1:0] clk_en_o
);
  p_frz_after_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frz_ack_o) |-> $past(!busy_i));

  p_frozen_isolated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_ack_o |-> (!presc_en_o && rx_ignore_o && tx_rec_o));

  p_ecr_only_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecr_we_o |-> frz_ack_o);

  p_ack_not_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_ack_o |-> not_rdy_o);

  p_ready_on_recessive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(not_rdy_o) |-> $past(bit_tick_i && rx_bit_i));

  p_frz_to_lpm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_ack_o && mdis_i) |=> (lpm_ack_o && !frz_ack_o && clk_en_o == '0));

  p_lpm_after_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lpm_ack_o) |-> $past(!busy_i));

  p_lpm_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpm_ack_o && !mdis_i) |=> (!lpm_ack_o && clk_en_o == '1 && not_rdy_o));

  p_acks_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frz_ack_o && lpm_ack_o));
endmodule

bind can_mode_seq can_mode_seq_chk #(.NUM_CLK_GATES(NUM_CLK_GATES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdis_i     (mdis_i),
  .busy_i     (busy_i),
  .bit_tick_i (bit_tick_i),
  .rx_bit_i   (rx_bit_i),
  .frz_ack_o  (frz_ack_o),
  .not_rdy_o  (not_rdy_o),
  .lpm_ack_o  (lpm_ack_o),
  .presc_en_o (presc_en_o),
  .rx_ignore_o(rx_ignore_o),
  .tx_rec_o   (tx_rec_o),
  .ecr_we_o   (ecr_we_o),
  .clk_en_o   (clk_en_o)
);

// File: tb/can_mode_seq_tb.sv
`timescale 1ns/1ps
module can_mode_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 0, frz_en = 0, debug = 0, mdis = 0;
  logic [2:0] bus_state = 0;
  logic       busy = 0, bit_tick = 0, rx_bit = 1;
  logic [1:0] intm_pos = 0;
  logic       frz_ack, not_rdy, lpm_ack, presc_en, rx_ignore, tx_rec, ecr_we;
  logic [1:0] clk_en;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  can_mode_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .frz_en_i(frz_en),
    .debug_i(debug), .mdis_i(mdis), .bus_state_i(bus_state), .busy_i(busy),
    .bit_tick_i(bit_tick), .rx_bit_i(rx_bit), .intm_pos_i(intm_pos),
    .frz_ack_o(frz_ack), .not_rdy_o(not_rdy), .lpm_ack_o(lpm_ack),
    .presc_en_o(presc_en), .rx_ignore_o(rx_ignore), .tx_rec_o(tx_rec),
    .ecr_we_o(ecr_we), .clk_en_o(clk_en)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input logic [1:0] pos);
    bit_tick = 1; rx_bit = v; intm_pos = pos;
    cyc(1);
    bit_tick = 0; rx_bit = 1;
  endtask

  task automatic go_run();
    bus_state = 0; busy = 0;
    for (int i = 0; i < 11; i++) send_bit(1'b1, 2'd0);
  endtask

  task automatic clear_req();
    halt = 0; frz_en = 0; debug = 0; mdis = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(1);
    // R12 reset state
    chk("R12 not_rdy", not_rdy, 1);
    chk("R12 frz_ack", frz_ack, 0);
    chk("R12 lpm_ack", lpm_ack, 0);
    chk("R12 presc_en", presc_en, 1);
    chk("R12 ecr_we", ecr_we, 0);
    chk("R12 clk_en", clk_en, 3);

    // R7 dominant bit restarts the count
    for (int i = 0; i < 10; i++) send_bit(1'b1, 2'd0);
    send_bit(1'b0, 2'd0);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 2'd0);
    chk("R7 still not ready after 10", not_rdy, 1);
    send_bit(1'b1, 2'd0);
    chk("R7 ready on 11th recessive", not_rdy, 0);
    chk("R4 ecr_we in run", ecr_we, 0);

    // R1 sweep all request bit combinations
    for (int c = 0; c < 16; c++) begin
      int ef, el;
      frz_en = c[0]; halt = c[1]; debug = c[2]; mdis = c[3];
      ef = (c[0] && (c[1] || c[2]) && !c[3]) ? 1 : 0;
      el = c[3] ? 1 : 0;
      cyc(2);
      chk("R1 no ack before 3rd edge", frz_ack, 0);
      cyc(1);
      chk($sformatf("R1 frz_ack combo %0d", c), frz_ack, ef);
      chk($sformatf("R9 lpm_ack combo %0d", c), lpm_ack, el);
      if (ef == 1) begin
        // R6 exit via halt/debug removal, frz_en kept
        halt = 0; debug = 0;
        cyc(1);
        chk("R6 frz_ack drops", frz_ack, 0);
        chk("R6 not_rdy held", not_rdy, 1);
      end
      if (el == 1) chk("R4 ecr_we disabled", ecr_we, 0);
      clear_req();
      cyc(1);
      go_run();
      chk("R7 back on bus", not_rdy, 0);
    end

    // R2 bus-state gating and busy gating for freeze
    for (int s = 0; s < 8; s++) begin
      int ok;
      ok = (s == 0 || s == 2 || s == 3 || s == 4) ? 1 : 0;
      bus_state = 1; busy = 1; frz_en = 1; halt = 1;
      cyc(3);
      chk("R2 waits during frame", frz_ack, 0);
      bus_state = 3'(s);
      cyc(3);
      chk("R2 waits while busy", frz_ack, 0);
      busy = 0;
      cyc(1);
      chk($sformatf("R2 frz_ack state %0d", s), frz_ack, ok);
      if (ok == 1) begin
        chk("R3 presc stopped", presc_en, 0);
        chk("R3 rx ignored", rx_ignore, 1);
        chk("R3 tx recessive", tx_rec, 1);
        chk("R4 ecr_we frozen", ecr_we, 1);
        chk("R5 not_rdy frozen", not_rdy, 1);
      end
      bus_state = 0;
      cyc(2);
      chk("R5 frozen after release", frz_ack, 1);
      frz_en = 0;
      cyc(1);
      chk("R6 exit via frz_en", frz_ack, 0);
      chk("R4 ecr_we after exit", ecr_we, 0);
      clear_req();
      go_run();
    end

    // R11 request dropped during bus-state wait
    bus_state = 1; frz_en = 1; debug = 1;
    cyc(1);
    frz_en = 0; debug = 0;
    cyc(2);
    bus_state = 0;
    cyc(2);
    chk("R11 still reaches freeze", frz_ack, 1);
    cyc(1);
    chk("R11 leaves freeze next edge", frz_ack, 0);
    go_run();

    // R8 / R10 disable from freeze and release
    frz_en = 1; halt = 1;
    cyc(3);
    chk("R8 frozen first", frz_ack, 1);
    mdis = 1;
    cyc(1);
    chk("R8 lpm_ack", lpm_ack, 1);
    chk("R8 frz_ack cleared", frz_ack, 0);
    chk("R8 clocks off", clk_en, 0);
    clear_req();
    cyc(1);
    chk("R10 lpm_ack cleared", lpm_ack, 0);
    chk("R10 clocks on", clk_en, 3);
    chk("R10 not_rdy held", not_rdy, 1);
    go_run();
    chk("R10 ready after resync", not_rdy, 0);

    // R9 disable gating over bus states
    for (int s = 0; s < 8; s++) begin
      int ok;
      ok = (s == 0 || s == 4) ? 1 : 0;
      bus_state = 1; busy = 1; mdis = 1;
      cyc(3);
      chk("R9 waits during frame", lpm_ack, 0);
      bus_state = 3'(s);
      cyc(2);
      busy = 0;
      cyc(1);
      chk($sformatf("R9 lpm_ack state %0d", s), lpm_ack, ok);
      bus_state = 0;
      cyc(2);
      chk("R9 disabled after idle", lpm_ack, 1);
      mdis = 0;
      cyc(1);
      go_run();
    end

    // R9 third intermission bit
    bus_state = 2; busy = 0; mdis = 1;
    cyc(1);
    send_bit(1'b1, 2'd0);
    send_bit(1'b1, 2'd1);
    send_bit(1'b0, 2'd2);
    cyc(2);
    chk("R9 dominant third bit holds", lpm_ack, 0);
    send_bit(1'b1, 2'd2);
    chk("R9 no ack same edge", lpm_ack, 0);
    cyc(1);
    chk("R9 recessive third bit proceeds", lpm_ack, 1);
    mdis = 0;
    cyc(1);
    go_run();
    chk("R7 final ready", not_rdy, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule